// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Controller

This block watches the instruction flow of an in-order, single-issue pipeline with five one-cycle stages (fetch, decode, execute, memory, writeback) and decides when a decoded instruction must wait and where each of its operands should come from. Each cycle the decoder presents the candidate instruction's source and destination register numbers and a few class bits: whether it writes a register, whether it is a load, and whether it is a store. The block keeps its own copies of those fields for the instructions in execute, memory and writeback. From them it drives three mux selects: the two execute-stage ALU operands and the memory-stage store-data path. It also drives a hold request, which freezes the PC and the fetch/decode register, and a bubble request, which empties the decode/execute register.

A bypass-enable input chooses between two modes. With bypass on, ALU results feed the next instructions directly. A load followed by a dependent instruction costs exactly one hold cycle. A store whose only dependence on a preceding load is its data word does not wait at all. With bypass off, every operand comes from the register file, and a consumer waits in decode until its producer has reached writeback. The register file is assumed to write in the first half of a cycle and read in the second half, so a decode read in the same cycle as the producer's writeback returns the new value.

Top module: `hazard_bypass_unit`

## Requirements
- R1: After reset, with no valid instruction in decode, hold and bubble are 0 and all three selects are 0.
- R2: With bypass on, a valid decode instruction is held for exactly one cycle when the instruction in execute is a load whose destination is a used source. The exception is a store whose only match is its data source. In the cycle after the held instruction enters execute, an operand that matches the load selects 2'b01 (writeback value).
- R3: With bypass on, an execute-stage source that matches the destination of a non-load in the memory stage selects 2'b10. This applies to both operands independently and never requests a hold.
- R4: When the memory-stage and writeback-stage instructions both write an execute-stage source, the memory-stage result (2'b10) wins over the writeback result (2'b01).
- R5: Register 0 never causes a hold and is never bypassed; its select stays 2'b00.
- R6: A store that directly follows its data producer needs no hold. Following an ALU op, operand B selects 2'b10 in execute. Following a load, the store-data select is 1 in the memory-stage cycle, when the writeback-stage instruction writes the store's data register.
- R7: With bypass off, all selects are 0. A valid decode instruction is held while any used non-zero source matches the destination of a writing instruction in execute or memory. It is not held when the only such producer is in writeback.
- R8: The sequence load, dependent add, dependent sub, dependent store takes 9 cycles from the first fetch to the last writeback with bypass on (one hold) and 14 cycles with bypass off (six holds).
- R9: Bubble is asserted in exactly the cycles in which hold is asserted. The bubble placed into execute has its register-write and load flags cleared.
- R10: An invalid decode slot, or a source marked unused, never causes a hold, whatever its register fields contain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| bypass_en_i | input | 1 | 1 enables result bypassing; 0 waits for writeback |
| id_valid_i | input | 1 | Decode slot holds a real instruction |
| id_rs1_i | input | 5 | First source register number |
| id_rs1_used_i | input | 1 | First source is read |
| id_rs2_i | input | 5 | Second source register number (store data for stores) |
| id_rs2_used_i | input | 1 | Second source is read |
| id_rd_i | input | 5 | Destination register number |
| id_wr_en_i | input | 1 | Instruction writes its destination |
| id_load_i | input | 1 | Instruction is a load |
| id_store_i | input | 1 | Instruction is a store |
| hold_o | output | 1 | Freeze PC and fetch/decode register |
| bubble_o | output | 1 | Load an empty slot into decode/execute |
| ex_opa_sel_o | output | 2 | Operand A source: 00 register file, 01 writeback, 10 memory stage |
| ex_opb_sel_o | output | 2 | Operand B source, same encoding |
| mem_st_sel_o | output | 1 | Store data from writeback result (1) or from the pipeline (0) |

## Verification
Hold and bubble are combinational on the decode inputs and are due in the same cycle that the consumer sits in decode. The operand selects are due one clock edge after the consumer leaves decode, while it occupies execute. The store-data select is due two edges after the store leaves decode. The driver sets the decode fields just after each rising edge and queues the outputs expected for that same cycle, counting those edges by hand for each case. The monitor takes each expected item at the following falling edge, so every comparison falls inside the cycle the result belongs to. The end-to-end cycle totals are derived from the number of hold cycles seen during each scripted sequence.

// File: rtl/hzu_pkg.sv
package hzu_pkg;

  localparam int unsigned REG_AW  = 5;  // register number width
  localparam int unsigned N_TRACK = 3;  // tracked stages: EX, MEM, WB
  localparam int unsigned N_OPER  = 2;  // execute operands
  localparam int unsigned SEL_W   = 2;

  typedef logic [REG_AW-1:0] reg_idx_t;

  typedef enum logic [SEL_W-1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } src_sel_e;

  typedef struct packed {
    logic     valid;
    reg_idx_t rs1;
    logic     rs1_used;
    reg_idx_t rs2;
    logic     rs2_used;
    reg_idx_t rd;
    logic     wr_en;
    logic     is_load;
    logic     is_store;
  } slot_t;

  // True when slot s will deliver a new value for register r.
  function automatic logic slot_writes(slot_t s, reg_idx_t r);
    return s.valid && s.wr_en && (s.rd != '0) && (s.rd == r);
  endfunction

endpackage

// File: rtl/hzu_slot_pipe.sv
module hzu_slot_pipe
  import hzu_pkg::*;
#(
  parameter int unsigned DEPTH = N_TRACK
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  slot_t                 id_slot_i,
  input  logic                  inject_i,
  output slot_t [DEPTH-1:0]     slot_o
);

  slot_t [DEPTH-1:0] slot_d;
  slot_t [DEPTH-1:0] slot_q;

  always_comb begin
    slot_d[0] = (inject_i || !id_slot_i.valid) ? '0 : id_slot_i;
    for (int i = 1; i < DEPTH; i++) begin
      slot_d[i] = slot_q[i-1];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[g] <= '0;
      else         slot_q[g] <= slot_d[g];
    end
  end

  assign slot_o = slot_q;

  // R9: an injected bubble carries no write or load into execute
  a_r9_bubble_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inject_i |=> (!slot_q[0].wr_en && !slot_q[0].is_load));

endmodule

// File: rtl/hzu_src_pick.sv
module hzu_src_pick
  import hzu_pkg::*;
(
  input  logic     bypass_en_i,
  input  logic     used_i,
  input  reg_idx_t rs_i,
  input  slot_t    mem_slot_i,
  input  slot_t    wb_slot_i,
  output src_sel_e sel_o
);

  logic mem_hit;
  logic wb_hit;

  // Load data is not ready at the end of execute, so a load in MEM is skipped.
  assign mem_hit = slot_writes(mem_slot_i, rs_i) && !mem_slot_i.is_load;
  assign wb_hit  = slot_writes(wb_slot_i, rs_i);

  always_comb begin
    sel_o = SRC_RF;
    if (bypass_en_i && used_i) begin
      if (mem_hit)     sel_o = SRC_MEM;  // younger result first
      else if (wb_hit) sel_o = SRC_WB;
    end
  end

endmodule

// File: rtl/hzu_hold_detect.sv
module hzu_hold_detect
  import hzu_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  bypass_en_i,
  input  slot_t id_slot_i,
  input  slot_t ex_slot_i,
  input  slot_t mem_slot_i,
  output logic  hold_o
);

  logic use_hit1_ld, use_hit2_ld;
  logic wait_hit1, wait_hit2;
  logic hold_bypass, hold_nobypass;

  always_comb begin
    // bypass on: only a load one stage ahead is too late
    use_hit1_ld = id_slot_i.rs1_used && ex_slot_i.is_load &&
                  slot_writes(ex_slot_i, id_slot_i.rs1);
    // store data is picked up later in the memory stage
    use_hit2_ld = id_slot_i.rs2_used && ex_slot_i.is_load && !id_slot_i.is_store &&
                  slot_writes(ex_slot_i, id_slot_i.rs2);
    // bypass off: any producer not yet in writeback
    wait_hit1   = id_slot_i.rs1_used &&
                  (slot_writes(ex_slot_i, id_slot_i.rs1) ||
                   slot_writes(mem_slot_i, id_slot_i.rs1));
    wait_hit2   = id_slot_i.rs2_used &&
                  (slot_writes(ex_slot_i, id_slot_i.rs2) ||
                   slot_writes(mem_slot_i, id_slot_i.rs2));
    hold_bypass   = use_hit1_ld || use_hit2_ld;
    hold_nobypass = wait_hit1 || wait_hit2;
    hold_o = id_slot_i.valid && (bypass_en_i ? hold_bypass : hold_nobypass);
  end

  // R2: with bypass on a hold never lasts beyond one cycle
  a_r2_single_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bypass_en_i && hold_o) |=> (!hold_o || !bypass_en_i));

  // R5: register 0 sources never hold
  a_r5_zero_no_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((id_slot_i.rs1 == '0 || !id_slot_i.rs1_used) &&
     (id_slot_i.rs2 == '0 || !id_slot_i.rs2_used)) |-> !hold_o);

  // R10: an empty decode slot never holds
  a_r10_idle_no_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_slot_i.valid |-> !hold_o);

endmodule

// File: rtl/hazard_bypass_unit.sv
module hazard_bypass_unit
  import hzu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bypass_en_i,
  input  logic              id_valid_i,
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic              id_rs1_used_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic              id_rs2_used_i,
  input  logic [REG_AW-1:0] id_rd_i,
  input  logic              id_wr_en_i,
  input  logic              id_load_i,
  input  logic              id_store_i,
  output logic              hold_o,
  output logic              bubble_o,
  output logic [SEL_W-1:0]  ex_opa_sel_o,
  output logic [SEL_W-1:0]  ex_opb_sel_o,
  output logic              mem_st_sel_o
);

  localparam int unsigned EX_IDX  = 0;
  localparam int unsigned MEM_IDX = 1;
  localparam int unsigned WB_IDX  = 2;

  slot_t                 id_slot;
  slot_t [N_TRACK-1:0]   trk;
  slot_t                 ex_s, mem_s, wb_s;
  logic                  hold;
  reg_idx_t              op_rs   [N_OPER];
  logic                  op_used [N_OPER];
  src_sel_e              op_sel  [N_OPER];

  always_comb begin
    id_slot.valid    = id_valid_i;
    id_slot.rs1      = id_rs1_i;
    id_slot.rs1_used = id_rs1_used_i;
    id_slot.rs2      = id_rs2_i;
    id_slot.rs2_used = id_rs2_used_i;
    id_slot.rd       = id_rd_i;
    id_slot.wr_en    = id_wr_en_i;
    id_slot.is_load  = id_load_i;
    id_slot.is_store = id_store_i;
  end

  hzu_hold_detect u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bypass_en_i (bypass_en_i),
    .id_slot_i   (id_slot),
    .ex_slot_i   (ex_s),
    .mem_slot_i  (mem_s),
    .hold_o      (hold)
  );

  hzu_slot_pipe #(.DEPTH(N_TRACK)) u_pipe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .id_slot_i (id_slot),
    .inject_i  (hold),
    .slot_o    (trk)
  );

  assign ex_s  = trk[EX_IDX];
  assign mem_s = trk[MEM_IDX];
  assign wb_s  = trk[WB_IDX];

  assign op_rs[0]   = ex_s.rs1;
  assign op_used[0] = ex_s.rs1_used;
  assign op_rs[1]   = ex_s.rs2;
  assign op_used[1] = ex_s.rs2_used;

  for (genvar g = 0; g < N_OPER; g++) begin : g_oper
    hzu_src_pick u_pick (
      .bypass_en_i (bypass_en_i),
      .used_i      (op_used[g]),
      .rs_i        (op_rs[g]),
      .mem_slot_i  (mem_s),
      .wb_slot_i   (wb_s),
      .sel_o       (op_sel[g])
    );
  end

  assign hold_o       = hold;
  assign bubble_o     = hold;
  assign ex_opa_sel_o = op_sel[0];
  assign ex_opb_sel_o = op_sel[1];
  assign mem_st_sel_o = bypass_en_i && mem_s.valid && mem_s.is_store &&
                        mem_s.rs2_used && slot_writes(wb_s, mem_s.rs2);

  // R7: no bypass select while bypass is off
  a_r7_rf_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bypass_en_i |-> (ex_opa_sel_o == SRC_RF && ex_opb_sel_o == SRC_RF && !mem_st_sel_o));

  // R3: the memory-stage source is never a load still fetching data
  a_r3_mem_src_alu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_opa_sel_o == SRC_MEM) |-> (mem_s.valid && !mem_s.is_load));

  // R4: the older writeback result is not taken while memory stage has a newer one
  a_r4_younger_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_opb_sel_o == SRC_WB) |-> !(slot_writes(mem_s, ex_s.rs2) && !mem_s.is_load));

  // R5: register 0 is never bypassed
  a_r5_zero_rf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_s.rs1 == '0) |-> (ex_opa_sel_o == SRC_RF));

endmodule

// File: tb/hazard_bypass_unit_bench.sv
module hazard_bypass_unit_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       byp;
  logic       v, u1, u2, we, ld, st;
  logic [4:0] rs1, rs2, rd;
  logic       hold_o, bubble_o, st_sel;
  logic [1:0] a_sel, b_sel;

  int n_chk = 0;
  int n_fail = 0;
  int hold_seen = 0;

  typedef struct {
    logic       h;
    logic [1:0] a;
    logic [1:0] b;
    logic       s;
    string      tag;
  } exp_t;

  exp_t sb_q[$];

  always #4 clk = ~clk;  // 125 MHz

  hazard_bypass_unit u_hazard_bypass_unit (
    .clk_i(clk), .rst_ni(rst_n), .bypass_en_i(byp),
    .id_valid_i(v), .id_rs1_i(rs1), .id_rs1_used_i(u1),
    .id_rs2_i(rs2), .id_rs2_used_i(u2), .id_rd_i(rd),
    .id_wr_en_i(we), .id_load_i(ld), .id_store_i(st),
    .hold_o(hold_o), .bubble_o(bubble_o),
    .ex_opa_sel_o(a_sel), .ex_opb_sel_o(b_sel), .mem_st_sel_o(st_sel)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // monitor: compare each queued expectation inside its own cycle
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      if (hold_o) hold_seen++;
      chk(hold_o === e.h,   e.tag, "hold",   int'(hold_o),   int'(e.h));
      chk(bubble_o === e.h, e.tag, "bubble", int'(bubble_o), int'(e.h));
      chk(a_sel === e.a,    e.tag, "opa",    int'(a_sel),    int'(e.a));
      chk(b_sel === e.b,    e.tag, "opb",    int'(b_sel),    int'(e.b));
      chk(st_sel === e.s,   e.tag, "stsel",  int'(st_sel),   int'(e.s));
    end
  end

  // driver helpers
  task automatic tick(); @(posedge clk); #1; endtask

  task automatic op_raw(input logic vv, input logic [4:0] a, input logic ua,
                        input logic [4:0] b, input logic ub, input logic [4:0] d,
                        input logic w, input logic l, input logic s);
    v = vv; rs1 = a; u1 = ua; rs2 = b; u2 = ub; rd = d; we = w; ld = l; st = s;
  endtask
  task automatic op_nop();  op_raw(0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic op_lw(input logic [4:0] d, input logic [4:0] base);
    op_raw(1, base, 1, 0, 0, d, 1, 1, 0);
  endtask
  task automatic op_alu(input logic [4:0] d, input logic [4:0] a, input logic [4:0] b);
    op_raw(1, a, 1, b, 1, d, 1, 0, 0);
  endtask
  task automatic op_sw(input logic [4:0] data, input logic [4:0] base);
    op_raw(1, base, 1, data, 1, 0, 0, 0, 1);
  endtask
  task automatic want(input logic h, input logic [1:0] a, input logic [1:0] b,
                      input logic s, input string tag);
    exp_t e;
    e.h = h; e.a = a; e.b = b; e.s = s; e.tag = tag;
    sb_q.push_back(e);
  endtask
  task automatic drain();
    @(negedge clk); #1;
  endtask

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; byp = 1'b1;
    op_nop();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state with an idle decode slot
    tick(); op_nop(); want(0, 0, 0, 0, "R1");
    tick(); op_nop(); want(0, 0, 0, 0, "R1");
    tick(); op_nop(); want(0, 0, 0, 0, "R1");

    // R2 R3 R6 R8: load/add/sub/store chain with bypass on
    hold_seen = 0;
    tick(); op_lw(1, 2);     want(0, 0, 0, 0, "R2");
    tick(); op_alu(3, 1, 4); want(1, 0, 0, 0, "R2 load-use hold");
    tick();                  want(0, 0, 0, 0, "R2 released");
    tick(); op_alu(5, 3, 1); want(0, 1, 0, 0, "R2 writeback source");
    tick(); op_sw(5, 6);     want(0, 2, 0, 0, "R3 mem source");
    tick(); op_nop();        want(0, 0, 2, 0, "R6 store data from ALU");
    tick(); op_nop();        want(0, 0, 0, 1, "R6 store data in MEM");
    tick(); op_nop();        want(0, 0, 0, 0, "R6");
    drain();
    chk(5 + 3 + hold_seen == 9, "R8", "bypass cycles", 5 + 3 + hold_seen, 9);

    // R7 R8: same chain with bypass off
    byp = 1'b0;
    hold_seen = 0;
    tick(); op_lw(1, 2);     want(0, 0, 0, 0, "R7");
    tick(); op_alu(3, 1, 4); want(1, 0, 0, 0, "R7 producer in EX");
    tick();                  want(1, 0, 0, 0, "R7 producer in MEM");
    tick();                  want(0, 0, 0, 0, "R7 producer in WB");
    tick(); op_alu(5, 3, 1); want(1, 0, 0, 0, "R7 no bypass select");
    tick();                  want(1, 0, 0, 0, "R7");
    tick();                  want(0, 0, 0, 0, "R7");
    tick(); op_sw(5, 6);     want(1, 0, 0, 0, "R7");
    tick();                  want(1, 0, 0, 0, "R7");
    tick();                  want(0, 0, 0, 0, "R7");
    tick(); op_nop();        want(0, 0, 0, 0, "R7");
    tick(); op_nop();        want(0, 0, 0, 0, "R7 no store bypass");
    tick(); op_nop();        want(0, 0, 0, 0, "R7");
    drain();
    chk(5 + 3 + hold_seen == 14, "R8", "no-bypass cycles", 5 + 3 + hold_seen, 14);
    byp = 1'b1;

    // R3 R4: both operands, two producers of the same register
    tick(); op_alu(7, 8, 9);   want(0, 0, 0, 0, "R4");
    tick(); op_alu(7, 10, 11); want(0, 0, 0, 0, "R4");
    tick(); op_alu(12, 7, 7);  want(0, 0, 0, 0, "R4");
    tick(); op_nop();          want(0, 2, 2, 0, "R4 younger wins");
    tick(); op_nop();          want(0, 0, 0, 0, "R3");
    tick(); op_nop();          want(0, 0, 0, 0, "R3");

    // R5: register 0 as load and ALU destination
    tick(); op_lw(0, 2);       want(0, 0, 0, 0, "R5");
    tick(); op_alu(15, 0, 0);  want(0, 0, 0, 0, "R5 no hold");
    tick(); op_alu(0, 3, 4);   want(0, 0, 0, 0, "R5");
    tick(); op_alu(16, 0, 0);  want(0, 0, 0, 0, "R5");
    tick(); op_nop();          want(0, 0, 0, 0, "R5 no bypass");
    tick(); op_nop();          want(0, 0, 0, 0, "R5");
    tick(); op_nop();          want(0, 0, 0, 0, "R5");

    // R6: load then store of the loaded value
    tick(); op_lw(1, 2);       want(0, 0, 0, 0, "R6");
    tick(); op_sw(1, 3);       want(0, 0, 0, 0, "R6 no hold");
    tick(); op_nop();          want(0, 0, 0, 0, "R6 load not in MEM src");
    tick(); op_nop();          want(0, 0, 0, 1, "R6 load to store data");
    tick(); op_nop();          want(0, 0, 0, 0, "R6");

    // R2 R9: store whose address depends on a load
    tick(); op_lw(1, 2);       want(0, 0, 0, 0, "R2");
    tick(); op_sw(4, 1);       want(1, 0, 0, 0, "R9 hold with bubble");
    tick();                    want(0, 0, 0, 0, "R9 bubble in EX");
    tick(); op_nop();          want(0, 1, 0, 0, "R2 address from WB");
    tick(); op_nop();          want(0, 0, 0, 0, "R9");
    tick(); op_nop();          want(0, 0, 0, 0, "R9");

    // R10: invalid slot and unused sources
    tick(); op_lw(1, 2);                      want(0, 0, 0, 0, "R10");
    tick(); op_raw(0, 1, 1, 1, 1, 9, 1, 0, 0); want(0, 0, 0, 0, "R10 invalid slot");
    tick(); op_lw(1, 2);                      want(0, 0, 0, 0, "R10");
    tick(); op_raw(1, 1, 0, 1, 0, 9, 1, 0, 0); want(0, 0, 0, 0, "R10 unused sources");
    tick(); op_nop();                         want(0, 0, 0, 0, "R10");
    tick(); op_nop();                         want(0, 0, 0, 0, "R10");
    tick(); op_nop();                         want(0, 0, 0, 0, "R10");
    drain();

    summary();
    $finish;
  end

endmodule